// File: doc/BRIEF.md
# Presettable Up/Down Counter with Ripple Clock

A synchronous counter whose modulus is chosen at build time: in decimal mode it cycles through 0 to 9, and in binary mode it cycles through the full range of its width (0 to 15 at the default width of four bits). One input selects the direction, an active-low enable lets it advance, and an active-low load copies a data word into the count. Load overrides counting.

The block raises a terminal flag at the last value in the current direction. That value is the maximum when counting up and zero when counting down. It also produces an active-low ripple clock. This output drops during the low phase of the clock while the terminal flag is set and counting is enabled. Its rising edge lines up with the clock edge on which this stage wraps, so it can clock the next more significant stage.

Each cycle the control decoder picks one operation, and the next-value logic carries it out. The operations are: HOLD, where the count keeps its value; LOAD, where the count takes the data word; INC, where the count steps up and wraps MAX→0; and DEC, where the count steps down and wraps 0→MAX. In decimal mode, an out-of-range value jumps straight back into range: INC goes to 0 and DEC goes to 9.

Top module: `updown_ripple_counter`

## Requirements
- R1: An active-low reset, applied asynchronously, clears the count to 0.
- R2: With load_n low at a rising clock edge, the count takes the value of load_val.
- R3: Load wins over counting: load_n low loads load_val whatever enable_n and down are.
- R4: With load_n high, enable_n low and down low (0 = up), the count rises by one per edge. It wraps 15→0 in binary mode and 9→0 in decimal mode.
- R5: With load_n high, enable_n low and down high (1 = down), the count falls by one per edge. It wraps 0→15 in binary mode and 0→9 in decimal mode.
- R6: term is high exactly when counting up with the count at MAX (9 decimal, 15 binary), or when counting down with the count at 0. It does not depend on enable_n.
- R7: With load_n high and enable_n high, the count does not change.
- R8: ripple_n is low only while clk is low, term is high and enable_n is low. At all other times it is high.
- R9: In decimal mode, counting from a value in 0..9 never leaves 0..9.
- R10: In decimal mode, a loaded value from 10 to 15 goes to 0 on the next up count and to 9 on the next down count.
- R11: Two decimal stages, the second clocked by the first's ripple_n, count together as a two-digit decimal number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low synchronous load |
| load_val | input | W | Value to load |
| down | input | 1 | 0 counts up, 1 counts down |
| enable_n | input | 1 | Active-low count enable |
| count | output | W | Current count |
| term | output | 1 | Terminal-count flag for the current direction |
| ripple_n | output | 1 | Active-low gated clock for the next stage |

## Verification
The assertions assume that every control input is settled at each rising clock edge. They also assume that, in decimal mode, out-of-range values enter only through a load. The bench changes inputs only a couple of time units after a rising edge, well away from the next one. It places invalid decimal values in the count only through load_val. In the cascade, the upper stage has its controls held constant, so its only clock is the lower stage's ripple output.

// File: rtl/udc_pkg.sv
package udc_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } udc_op_e;
endpackage

// File: rtl/udc_ctrl.sv
module udc_ctrl
    import udc_pkg::*;
(
    input  logic    load_n,
    input  logic    enable_n,
    input  logic    down,
    output udc_op_e op
);
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (enable_n)
            op = OP_HOLD;
        else if (down)
            op = OP_DEC;
        else
            op = OP_INC;
    end
endmodule

// File: rtl/udc_next.sv
module udc_next
    import udc_pkg::*;
#(
    parameter int W        = 4,
    parameter bit BCD_MODE = 1'b0
) (
    input  udc_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   load_val,
    output logic [W-1:0]   nxt
);
    localparam logic [W-1:0] MAX = BCD_MODE ? W'(9) : {W{1'b1}};

    always_comb begin
        unique case (op)
            OP_HOLD: nxt = cur;
            OP_LOAD: nxt = load_val;
            OP_INC:  nxt = (cur >= MAX) ? '0 : cur + W'(1);
            OP_DEC:  nxt = (cur == '0 || cur > MAX) ? MAX : cur - W'(1);
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/udc_flags.sv
module udc_flags #(
    parameter int W        = 4,
    parameter bit BCD_MODE = 1'b0
) (
    input  logic         clk,
    input  logic [W-1:0] cur,
    input  logic         down,
    input  logic         enable_n,
    output logic         term,
    output logic         ripple_n
);
    localparam logic [W-1:0] MAX = BCD_MODE ? W'(9) : {W{1'b1}};

    always_comb begin
        term     = down ? (cur == '0) : (cur == MAX);
        ripple_n = ~(~clk & term & ~enable_n);
    end
endmodule

// File: rtl/updown_ripple_counter.sv
module updown_ripple_counter
    import udc_pkg::*;
#(
    parameter int W        = 4,
    parameter bit BCD_MODE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] load_val,
    input  logic         down,
    input  logic         enable_n,
    output logic [W-1:0] count,
    output logic         term,
    output logic         ripple_n
);
    localparam logic [W-1:0] MAX = BCD_MODE ? W'(9) : {W{1'b1}};

    udc_op_e      op;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    udc_ctrl u_ctrl (
        .load_n   (load_n),
        .enable_n (enable_n),
        .down     (down),
        .op       (op)
    );

    udc_next #(.W(W), .BCD_MODE(BCD_MODE)) u_next (
        .op       (op),
        .cur      (cnt_q),
        .load_val (load_val),
        .nxt      (cnt_d)
    );

    udc_flags #(.W(W), .BCD_MODE(BCD_MODE)) u_flags (
        .clk      (clk),
        .cur      (cnt_q),
        .down     (down),
        .enable_n (enable_n),
        .term     (term),
        .ripple_n (ripple_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R2 / R3: a load is taken regardless of the other controls
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> cnt_q == $past(load_val));

    // R7: disabled counter keeps its value
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && enable_n) |=> $stable(cnt_q));

    // R4: terminal flag while counting up is followed by zero
    assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !enable_n && !down && term) |=> cnt_q == '0);

    // R5: terminal flag while counting down is followed by MAX
    assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !enable_n && down && term) |=> cnt_q == MAX);

    generate
        if (BCD_MODE) begin : g_bcd_checks
            // R9: valid decimal digits stay valid
            assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (load_n && cnt_q <= MAX) |=> cnt_q <= MAX);
            // R10: an invalid value returns to the range on the next count
            assert_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (load_n && !enable_n && cnt_q > MAX) |=> cnt_q <= MAX);
        end
    endgenerate
endmodule

// File: tb/updown_ripple_counter_test.sv
module updown_ripple_counter_test;
    localparam int  W      = 4;
    localparam time PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    // binary stage
    logic         load_n = 1'b1, down = 1'b0, enable_n = 1'b1;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic         term, ripple_n;

    // decimal cascade
    logic         lo_load_n = 1'b1, lo_down = 1'b0, lo_en_n = 1'b1;
    logic [W-1:0] lo_val = '0;
    logic [W-1:0] lo_cnt, hi_cnt;
    logic         lo_term, lo_rc, hi_term, hi_rc;

    int checks = 0;
    int errors = 0;

    updown_ripple_counter #(.W(W), .BCD_MODE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
        .down(down), .enable_n(enable_n), .count(count), .term(term),
        .ripple_n(ripple_n));

    updown_ripple_counter #(.W(W), .BCD_MODE(1'b1)) u_lo (
        .clk(clk), .rst_n(rst_n), .load_n(lo_load_n), .load_val(lo_val),
        .down(lo_down), .enable_n(lo_en_n), .count(lo_cnt), .term(lo_term),
        .ripple_n(lo_rc));

    updown_ripple_counter #(.W(W), .BCD_MODE(1'b1)) u_hi (
        .clk(lo_rc), .rst_n(rst_n), .load_n(1'b1), .load_val(4'd0),
        .down(1'b0), .enable_n(1'b0), .count(hi_cnt), .term(hi_term),
        .ripple_n(hi_rc));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance one rising edge, land 2 units after it
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        chk("R1 count after reset", int'(count), 0);
        chk("R6 term up at 0", int'(term), 0);
        chk("R1 decimal count after reset", int'(lo_cnt), 0);
    endtask

    task automatic t_load();
        load_n = 1'b0; load_val = 4'd5; enable_n = 1'b1;
        tick();
        chk("R2 load 5", int'(count), 5);
        load_val = 4'd13; enable_n = 1'b0; down = 1'b1;
        tick();
        chk("R3 load beats down count", int'(count), 13);
        load_n = 1'b1; down = 1'b0;
    endtask

    task automatic t_up();
        // count is 13, up
        tick(); chk("R4 up 14", int'(count), 14);
        tick(); chk("R4 up 15", int'(count), 15);
        #1; chk("R6 term at 15 up", int'(term), 1);
        tick(); chk("R4 wrap 15->0", int'(count), 0);
        chk("R6 term clear at 0 up", int'(term), 0);
    endtask

    task automatic t_down();
        load_n = 1'b0; load_val = 4'd1; tick();
        load_n = 1'b1; down = 1'b1; enable_n = 1'b0;
        tick(); chk("R5 down 0", int'(count), 0);
        #1; chk("R6 term at 0 down", int'(term), 1);
        tick(); chk("R5 wrap 0->15", int'(count), 15);
        chk("R6 term clear at 15 down", int'(term), 0);
    endtask

    task automatic t_hold();
        enable_n = 1'b1;
        tick(); tick();
        chk("R7 hold", int'(count), 15);
        down = 1'b0;
        #1; chk("R6 term set with enable off", int'(term), 1);
    endtask

    task automatic t_ripple();
        // count 15, up, term high; enable off first
        #3; // clk low phase
        chk("R8 ripple high when disabled", int'(ripple_n), 1);
        tick();
        enable_n = 1'b0;
        load_n = 1'b0; load_val = 4'd15; tick(); load_n = 1'b1;
        chk("R8 ripple high while clk high", int'(ripple_n), 1);
        #4;
        chk("R8 ripple low in clk low phase", int'(ripple_n), 0);
        tick();
        chk("R4 wrap after ripple", int'(count), 0);
        #4;
        chk("R8 ripple high without term", int'(ripple_n), 1);
        enable_n = 1'b1;
    endtask

    task automatic t_cascade();
        lo_en_n = 1'b0; lo_down = 1'b0;
        for (int i = 0; i < 25; i++) tick();
        chk("R11 units digit", int'(lo_cnt), 5);
        chk("R11 tens digit", int'(hi_cnt), 2);
        chk("R9 units in range", int'(lo_cnt <= 9), 1);
        lo_en_n = 1'b1;
    endtask

    task automatic t_bcd_wrap();
        lo_load_n = 1'b0; lo_val = 4'd9; tick();
        lo_load_n = 1'b1; lo_en_n = 1'b0;
        tick(); chk("R4 decimal wrap 9->0", int'(lo_cnt), 0);
        lo_down = 1'b1;
        tick(); chk("R5 decimal wrap 0->9", int'(lo_cnt), 9);
        tick(); chk("R5 decimal down 8", int'(lo_cnt), 8);
        lo_en_n = 1'b1;
    endtask

    task automatic t_bcd_invalid();
        lo_load_n = 1'b0; lo_val = 4'd12; lo_down = 1'b0; tick();
        chk("R2 decimal load 12", int'(lo_cnt), 12);
        lo_load_n = 1'b1; lo_en_n = 1'b0;
        tick(); chk("R10 12 up -> 0", int'(lo_cnt), 0);
        lo_load_n = 1'b0; lo_val = 4'd14; lo_down = 1'b1; tick();
        lo_load_n = 1'b1;
        tick(); chk("R10 14 down -> 9", int'(lo_cnt), 9);
        lo_en_n = 1'b1;
    endtask

    initial begin : watchdog
        #(PERIOD * 5000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        #(PERIOD * 2 + 3);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_load();
        t_up();
        t_down();
        t_hold();
        t_ripple();
        t_cascade();
        t_bcd_wrap();
        t_bcd_invalid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule